// File: doc/BRIEF.md
# Companion-Chip Register File with Interrupt Logic

This block is the register file of a power-management companion chip. It sits behind the read and write strobes of a serial bus slave and holds 32 word slots of 16 bits each, addressed by a 5-bit index. Only some of these slots are implemented. They are:

- an interrupt status word, acknowledged by writing the bits to be toggled;
- an interrupt mask, in which a 1 blocks that source;
- a fixed identity word that carries a variant strap bit;
- a converter slot with a channel selector, whose results come from a built-in preset table;
- a sample-control word that is cleared bit by bit;
- a calibration word;
- two general control words;
- a read-only status word that reflects the power key;
- a watchdog slot that can request a system shutdown.

The bus slave places an index on `addr_i`. Read data on `rdata_o` reflects the current register contents in the same cycle. A write strobe commits `wdata_i` on the next rising clock edge. The block drives a level interrupt `irq_o`, which is high while any unmasked status bit is set. It also drives a one-cycle `shutdown_o` pulse.

Top module: `pmic_regfile`

## Requirements
- R1: After reset the interrupt status (index 1) reads 0x0000, the mask (index 2) reads 0xFFFF, the calibration word (index 6) reads 0x0001, both control words (0x0D, 0x0E) read 0x0000, the status word (0x16) reads 0x0020, the sample-control word (index 9) reads the SAMPLE_INIT parameter (default 0x00FF), and `irq_o` and `shutdown_o` are low.
- R2: `irq_o` is high exactly when some bit is 1 in the interrupt status and 0 in the mask. It follows a status or mask change in the cycle after the write edge.
- R3: A write to index 1 XORs the written word into the interrupt status. A read of index 1 returns the raw status.
- R4: The mask at index 2 is read/write and returns the last written word.
- R5: Index 0 reads 0x0215 when `variant_i` is low and 0x0295 when it is high (bit 7 follows the strap).
- R6: A write to index 8 selects the channel from bits 13..10 of the written word and sets interrupt status bit 8.
- R7: A read of index 8 returns the selected channel in bits 13..10, ORed with that channel's 10-bit preset result in bits 9..0. Bits 15..14 read 0. The preset results by channel are: 1:0x3C2, 2:0x0FC, 3:0x165, 4:0x07B, 5:0x3FF, 6:0x011, 7:0x011, 8:0x250, 10:0x002, 11:0x011, 12:0x3D0, 13:0x330. Channels 0, 9, 14 and 15 read 0.
- R8: A write to index 9 clears every sample-control bit that is 1 in the written word and leaves the other bits unchanged.
- R9: Writing 0x0000 to index 0x17 raises `shutdown_o` for exactly one cycle after the write edge, but only if bit 1 of the control word at 0x0D is set. A nonzero watchdog write never raises it, and index 0x17 reads 0.
- R10: A power-key event (`key_evt_i` high for one cycle) sets interrupt status bit 0. It also sets status word bit 5 to the inverse of `key_pressed_i`: pressed gives 0, released gives 1.
- R11: The calibration word at index 6 is read/write.
- R12: The control words at 0x0D and 0x0E are read/write and independent of each other.
- R13: Writes to the identity and status words have no effect. Every index outside the implemented set reads 0, and writes to those indices are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| variant_i | input | 1 | Variant strap, reported in identity bit 7 |
| wr_en_i | input | 1 | Write strobe from the bus slave |
| addr_i | input | 5 | Register index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational from the registers |
| key_evt_i | input | 1 | One-cycle power-key event |
| key_pressed_i | input | 1 | Key level that goes with `key_evt_i` |
| irq_o | output | 1 | Interrupt, high while an unmasked status bit is set |
| shutdown_o | output | 1 | One-cycle shutdown request |

## Verification
A write presented before rising edge N is visible on `rdata_o` and `irq_o` from edge N onward. The `shutdown_o` pulse occupies exactly the cycle between edges N and N+1. Reads need no wait, because `rdata_o` decodes the current index in the same cycle. The bench drives inputs 1 ns after each rising edge and steps its behavioural model on that same edge. It compares all three outputs against the model at every falling edge, so each result is checked in the first cycle it is due, and a pulse that arrives late or lasts too long is caught.

// File: rtl/pmic_pkg.sv
package pmic_pkg;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 5;
    localparam int CH_W   = 4;
    localparam int RES_W  = 10;
    localparam int CH_LSB = RES_W;

    localparam logic [IDX_W-1:0] IDX_IDENT  = 5'h00;
    localparam logic [IDX_W-1:0] IDX_ISTAT  = 5'h01;
    localparam logic [IDX_W-1:0] IDX_IMASK  = 5'h02;
    localparam logic [IDX_W-1:0] IDX_CAL    = 5'h06;
    localparam logic [IDX_W-1:0] IDX_CONV   = 5'h08;
    localparam logic [IDX_W-1:0] IDX_SAMPLE = 5'h09;
    localparam logic [IDX_W-1:0] IDX_CTL_A  = 5'h0D;
    localparam logic [IDX_W-1:0] IDX_CTL_B  = 5'h0E;
    localparam logic [IDX_W-1:0] IDX_PSTAT  = 5'h16;
    localparam logic [IDX_W-1:0] IDX_WDOG   = 5'h17;

    localparam int SRC_KEY      = 0;
    localparam int SRC_CONV     = 8;
    localparam int VARIANT_BIT  = 7;
    localparam int KEY_UP_BIT   = 5;
    localparam int WDOG_EN_BIT  = 1;

    localparam logic [DATA_W-1:0] PSTAT_INIT = 16'h0020;
    localparam logic [DATA_W-1:0] MASK_INIT  = 16'hFFFF;

    function automatic logic [RES_W-1:0] preset_result(input logic [CH_W-1:0] ch);
        logic [RES_W-1:0] r;
        case (ch)
            4'd1:    r = 10'h3C2;
            4'd2:    r = 10'h0FC;
            4'd3:    r = 10'h165;
            4'd4:    r = 10'h07B;
            4'd5:    r = 10'h3FF;
            4'd6:    r = 10'h011;
            4'd7:    r = 10'h011;
            4'd8:    r = 10'h250;
            4'd10:   r = 10'h002;
            4'd11:   r = 10'h011;
            4'd12:   r = 10'h3D0;
            4'd13:   r = 10'h330;
            default: r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pmic_irq.sv
module pmic_irq
    import pmic_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] set_i,
    output logic [DATA_W-1:0] stat_o,
    output logic [DATA_W-1:0] mask_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] mask;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && addr_i == IDX_ISTAT) begin
            st_d.stat = st_q.stat ^ wdata_i;
        end
        if (wr_en_i && addr_i == IDX_IMASK) begin
            st_d.mask = wdata_i;
        end
        st_d.stat = st_d.stat | set_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.stat <= '0;
            st_q.mask <= MASK_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.stat & ~st_q.mask);
endmodule

// File: rtl/pmic_conv.sv
module pmic_conv
    import pmic_pkg::*;
#(
    parameter logic [DATA_W-1:0] SAMPLE_INIT = 16'h00FF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] conv_rd_o,
    output logic [DATA_W-1:0] sample_o,
    output logic              done_o
);
    localparam int PAD_W = DATA_W - CH_W - RES_W;

    typedef struct packed {
        logic [CH_W-1:0]   ch;
        logic [DATA_W-1:0] sample;
    } conv_state_t;

    conv_state_t st_d, st_q;
    logic conv_wr, sample_wr;

    always_comb begin
        conv_wr   = wr_en_i && addr_i == IDX_CONV;
        sample_wr = wr_en_i && addr_i == IDX_SAMPLE;
        st_d = st_q;
        if (conv_wr) begin
            st_d.ch = wdata_i[CH_LSB +: CH_W];
        end
        if (sample_wr) begin
            st_d.sample = st_q.sample & ~wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.ch     <= '0;
            st_q.sample <= SAMPLE_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign conv_rd_o = {{PAD_W{1'b0}}, st_q.ch, preset_result(st_q.ch)};
    assign sample_o  = st_q.sample;
    assign done_o    = conv_wr;
endmodule

// File: rtl/pmic_ctrl.sv
module pmic_ctrl
    import pmic_pkg::*;
#(
    parameter logic [DATA_W-1:0] CAL_INIT = 16'h0001
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              key_evt_i,
    input  logic              key_pressed_i,
    output logic [DATA_W-1:0] ctl_a_o,
    output logic [DATA_W-1:0] ctl_b_o,
    output logic [DATA_W-1:0] cal_o,
    output logic [DATA_W-1:0] pstat_o,
    output logic              shutdown_o
);
    typedef struct packed {
        logic [DATA_W-1:0] ctl_a;
        logic [DATA_W-1:0] ctl_b;
        logic [DATA_W-1:0] cal;
        logic [DATA_W-1:0] pstat;
        logic              sd;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sd = 1'b0;
        if (wr_en_i) begin
            case (addr_i)
                IDX_CTL_A: st_d.ctl_a = wdata_i;
                IDX_CTL_B: st_d.ctl_b = wdata_i;
                IDX_CAL:   st_d.cal   = wdata_i;
                IDX_WDOG:  st_d.sd    = (wdata_i == '0) && st_q.ctl_a[WDOG_EN_BIT];
                default:   ;
            endcase
        end
        if (key_evt_i) begin
            st_d.pstat[KEY_UP_BIT] = ~key_pressed_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.ctl_a <= '0;
            st_q.ctl_b <= '0;
            st_q.cal   <= CAL_INIT;
            st_q.pstat <= PSTAT_INIT;
            st_q.sd    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_a_o    = st_q.ctl_a;
    assign ctl_b_o    = st_q.ctl_b;
    assign cal_o      = st_q.cal;
    assign pstat_o    = st_q.pstat;
    assign shutdown_o = st_q.sd;
endmodule

// File: rtl/pmic_regfile.sv
module pmic_regfile
    import pmic_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_BASE     = 16'h0215,
    parameter logic [DATA_W-1:0] SAMPLE_INIT = 16'h00FF,
    parameter logic [DATA_W-1:0] CAL_INIT    = 16'h0001
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              variant_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              key_evt_i,
    input  logic              key_pressed_i,
    output logic              irq_o,
    output logic              shutdown_o
);
    logic [DATA_W-1:0] irq_stat, irq_mask, irq_set;
    logic [DATA_W-1:0] conv_rd, sample_val;
    logic [DATA_W-1:0] ctl_a, ctl_b, cal_val, pstat_val;
    logic [DATA_W-1:0] ident;
    logic              conv_done;

    always_comb begin
        irq_set = '0;
        irq_set[SRC_KEY]  = key_evt_i;
        irq_set[SRC_CONV] = conv_done;
    end

    pmic_irq u_irq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .set_i   (irq_set),
        .stat_o  (irq_stat),
        .mask_o  (irq_mask),
        .irq_o   (irq_o)
    );

    pmic_conv #(.SAMPLE_INIT(SAMPLE_INIT)) u_conv (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .conv_rd_o (conv_rd),
        .sample_o  (sample_val),
        .done_o    (conv_done)
    );

    pmic_ctrl #(.CAL_INIT(CAL_INIT)) u_ctrl (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_en_i       (wr_en_i),
        .addr_i        (addr_i),
        .wdata_i       (wdata_i),
        .key_evt_i     (key_evt_i),
        .key_pressed_i (key_pressed_i),
        .ctl_a_o       (ctl_a),
        .ctl_b_o       (ctl_b),
        .cal_o         (cal_val),
        .pstat_o       (pstat_val),
        .shutdown_o    (shutdown_o)
    );

    always_comb begin
        ident = ID_BASE;
        ident[VARIANT_BIT] = ident[VARIANT_BIT] | variant_i;
        case (addr_i)
            IDX_IDENT:  rdata_o = ident;
            IDX_ISTAT:  rdata_o = irq_stat;
            IDX_IMASK:  rdata_o = irq_mask;
            IDX_CAL:    rdata_o = cal_val;
            IDX_CONV:   rdata_o = conv_rd;
            IDX_SAMPLE: rdata_o = sample_val;
            IDX_CTL_A:  rdata_o = ctl_a;
            IDX_CTL_B:  rdata_o = ctl_b;
            IDX_PSTAT:  rdata_o = pstat_val;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/pmic_regfile_chk.sv
module pmic_regfile_chk
    import pmic_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [IDX_W-1:0]  addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              key_evt_i,
    input logic              shutdown_o,
    input logic [DATA_W-1:0] irq_stat,
    input logic [DATA_W-1:0] irq_mask
);
    // R3: status toggles by the written word when no event interferes
    a_r3_xor_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == IDX_ISTAT && !key_evt_i)
        |=> (irq_stat == ($past(irq_stat) ^ $past(wdata_i))));

    // R4: mask takes the written word
    a_r4_mask_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == IDX_IMASK) |=> (irq_mask == $past(wdata_i)));

    // R6: converter write raises sample-done
    a_r6_conv_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == IDX_CONV) |=> irq_stat[SRC_CONV]);

    // R9: shutdown only follows a zero watchdog write
    a_r9_sd_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shutdown_o |-> $past(wr_en_i && addr_i == IDX_WDOG && wdata_i == '0));

    // R10: key event raises its status bit
    a_r10_key_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        key_evt_i |=> irq_stat[SRC_KEY]);
endmodule

bind pmic_regfile pmic_regfile_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .key_evt_i  (key_evt_i),
    .shutdown_o (shutdown_o),
    .irq_stat   (irq_stat),
    .irq_mask   (irq_mask)
);

// File: tb/pmic_regfile_tb.sv
`timescale 1ns/1ps
module pmic_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        variant = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        kevt = 1'b0;
    logic        kprs = 1'b0;
    logic        irq, sd;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    string req = "R1";

    always #2 clk = ~clk;

    pmic_regfile dut_i (
        .clk_i(clk), .rst_ni(rst_n), .variant_i(variant), .wr_en_i(we),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .key_evt_i(kevt),
        .key_pressed_i(kprs), .irq_o(irq), .shutdown_o(sd)
    );

    // behavioural reference
    int m_stat, m_mask, m_ch, m_sample, m_cal, m_ca, m_cb, m_ps, m_sd;

    function automatic int res_of(input int ch);
        int t[16] = '{0, 'h3C2, 'h0FC, 'h165, 123, 1023, 'h11, 'h11,
                      'h250, 0, 2, 'h11, 'h3D0, 'h330, 0, 0};
        return t[ch];
    endfunction

    function automatic int exp_rd(input int a);
        case (a)
            0:    return variant ? 'h0295 : 'h0215;
            1:    return m_stat;
            2:    return m_mask;
            6:    return m_cal;
            8:    return (m_ch * 1024) + res_of(m_ch);
            9:    return m_sample;
            'hD:  return m_ca;
            'hE:  return m_cb;
            'h16: return m_ps;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = 0; m_mask = 'hFFFF; m_ch = 0; m_sample = 'h00FF;
            m_cal = 1; m_ca = 0; m_cb = 0; m_ps = 'h20; m_sd = 0;
        end else begin
            int ns, nsd;
            ns = m_stat; nsd = 0;
            if (we) begin
                case (int'(addr))
                    1:    ns = m_stat ^ int'(wdata);
                    2:    m_mask = int'(wdata);
                    6:    m_cal = int'(wdata);
                    8:    begin m_ch = (int'(wdata) / 1024) % 16; ns = ns | 'h100; end
                    9:    m_sample = m_sample & ~int'(wdata) & 'hFFFF;
                    'h17: nsd = (wdata == 0 && (m_ca & 2) != 0) ? 1 : 0;
                    default: ;
                endcase
                if (addr == 5'hD) m_ca = int'(wdata);
                if (addr == 5'hE) m_cb = int'(wdata);
            end
            if (kevt) begin
                ns = ns | 1;
                m_ps = kprs ? (m_ps & ~'h20) : (m_ps | 'h20);
            end
            m_stat = ns; m_sd = nsd;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int er, ei;
            er = exp_rd(int'(addr));
            ei = ((m_stat & ~m_mask & 'hFFFF) != 0) ? 1 : 0;
            n_cmp++;
            if (int'(rdata) != er || int'(irq) != ei || int'(sd) != m_sd) begin
                n_bad++;
                $display("FAIL %s addr=%02h: rdata=%04h irq=%0d sd=%0d expected rdata=%04h irq=%0d sd=%0d",
                         req, addr, rdata, irq, sd, er, ei, m_sd);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input string r);
        req = r;
        step(); we = 1'b1; addr = a; wdata = d;
        step(); we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input string r);
        req = r;
        step(); we = 1'b0; addr = a;
    endtask

    task automatic key(input logic p, input string r);
        req = r;
        step(); kevt = 1'b1; kprs = p;
        step(); kevt = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        foreach (addr[i]) ;
        rd(5'h01, "R1"); rd(5'h02, "R1"); rd(5'h06, "R1"); rd(5'h09, "R1");
        rd(5'h0D, "R1"); rd(5'h0E, "R1"); rd(5'h16, "R1"); rd(5'h08, "R1");
        // R5 identity with both strap levels, R13 write ignored
        rd(5'h00, "R5"); variant = 1'b1; rd(5'h00, "R5"); rd(5'h00, "R5");
        wr(5'h00, 16'hFFFF, "R13"); rd(5'h00, "R13");
        // R4 mask
        wr(5'h02, 16'h00FE, "R4"); rd(5'h02, "R4");
        // R3 / R2 toggle acknowledge and irq gating
        wr(5'h01, 16'h0003, "R3"); rd(5'h01, "R2");
        wr(5'h01, 16'h0002, "R3"); rd(5'h01, "R2");
        wr(5'h01, 16'h0001, "R3"); rd(5'h01, "R3");
        // R6 / R7 all channels
        for (int c = 0; c < 16; c++) begin
            wr(5'h08, 16'(c << 10) | 16'h03FF, "R6"); rd(5'h08, "R7"); rd(5'h01, "R6");
            wr(5'h01, 16'h0100, "R3");
        end
        wr(5'h02, 16'hFFFF, "R2"); wr(5'h08, 16'h1400, "R2"); rd(5'h01, "R2");
        wr(5'h02, 16'hFEFF, "R2"); rd(5'h08, "R7");
        // R8 sample clear
        wr(5'h09, 16'h000F, "R8"); rd(5'h09, "R8");
        wr(5'h09, 16'hFF00, "R8"); rd(5'h09, "R8");
        wr(5'h09, 16'h00F0, "R8"); rd(5'h09, "R8");
        // R11 / R12
        wr(5'h06, 16'hABCD, "R11"); rd(5'h06, "R11");
        wr(5'h0D, 16'h1234, "R12"); wr(5'h0E, 16'h5678, "R12");
        rd(5'h0D, "R12"); rd(5'h0E, "R12");
        // R9 watchdog
        wr(5'h0D, 16'h0000, "R9"); wr(5'h17, 16'h0000, "R9"); rd(5'h17, "R9");
        wr(5'h0D, 16'h0002, "R9"); wr(5'h17, 16'h0005, "R9"); rd(5'h17, "R9");
        wr(5'h17, 16'h0000, "R9"); rd(5'h17, "R9"); rd(5'h17, "R9");
        req = "R9";
        step(); we = 1'b1; addr = 5'h17; wdata = 16'h0000;
        step(); step(); we = 1'b0;
        rd(5'h17, "R9");
        // R10 key events, alone and against a status write
        wr(5'h02, 16'h0000, "R10");
        key(1'b1, "R10"); rd(5'h16, "R10"); rd(5'h01, "R10");
        key(1'b0, "R10"); rd(5'h16, "R10");
        req = "R10";
        step(); we = 1'b1; addr = 5'h01; wdata = 16'h0001; kevt = 1'b1; kprs = 1'b1;
        step(); we = 1'b0; kevt = 1'b0;
        rd(5'h01, "R10"); rd(5'h16, "R10");
        // R13 unimplemented and read-only slots
        wr(5'h16, 16'h0000, "R13"); rd(5'h16, "R13");
        for (int a = 0; a < 32; a++) begin
            if (a == 3 || a == 5 || a == 7 || a == 'h10 || a == 'h1F) begin
                wr(5'(a), 16'hFFFF, "R13"); rd(5'(a), "R13");
            end
        end
        rd(5'h01, "R13"); rd(5'h02, "R13"); rd(5'h06, "R13"); rd(5'h09, "R13");
        // R1 again after a second reset
        req = "R1";
        step(); rst_n = 1'b0; step(); step(); rst_n = 1'b1;
        rd(5'h02, "R1"); rd(5'h01, "R1"); rd(5'h16, "R1"); rd(5'h06, "R1");
        step();
        finish_run();
    end
endmodule